// File: doc/BRIEF.md
# Converter Startup and Role-Strap Controller

This block brings the digital side of a stereo audio converter out of reset. While the external reset pin is low, the controller holds everything in a low-power hold state. It also keeps the serial-data pad undriven, so that an external resistor alone sets the pad level. Reset assertion acts at once. Reset release is brought into the master-clock domain through a short flop chain.

On the first master-clock edge after the synchronized release, the controller reads the pad level once. A high level (pull-up) makes the converter the clock master, and a low level (pull-down) makes it a slave. From that edge on, the pad is driven. The controller then counts rising edges of the word (left/right) clock. Only when a programmable number of word periods has been seen does it raise `ready_o` and let serial bits through. Until then it sends zeros.

The shared divide pin is decoded according to the latched role. For a master, the pin selects high-rate mode (up to about 100 kHz) over base-rate mode (up to about 50 kHz). For a slave, the pin asks for the incoming master clock to be halved internally.

Top module: `adc_startup_ctrl`

## Requirements
- R1: While `rst_pin_n_i` is low, `low_power_o` is 1 and every other output is 0, and this takes effect without waiting for a clock edge.
- R2: After `rst_pin_n_i` rises, `low_power_o` falls and `data_oe_o` rises on the (SYNC_STAGES+1)-th rising clock edge, and not earlier.
- R3: On that edge, `strap_i` is latched into `role_master_o`: strap level 1 gives master (1), and strap level 0 gives slave (0).
- R4: Changes of `strap_i` after that edge do not alter `role_master_o` until the next reset.
- R5: `ready_o` is 0 until SETTLE_PERIODS word-clock rising edges have been detected after leaving hold. It becomes 1 right after the clock edge that detects the last of them, and it then stays 1 until reset.
- R6: Outside hold, `data_oe_o` is 1. `data_o` is 0 while `ready_o` is 0, and equals `tx_bit_i` while `ready_o` is 1.
- R7: In master role, `rate_high_o` equals `div_i` (1 = high-rate, 0 = base-rate) and `mclk_half_o` is 0.
- R8: In slave role, `mclk_half_o` equals `div_i` (1 = halve master clock, 0 = pass unchanged) and `rate_high_o` is 0.
- R9: A word clock held high for several master-clock cycles counts as one period only, because counting is edge based.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_pin_n_i | input | 1 | External reset, active low, asynchronous |
| strap_i | input | 1 | Pad level of the serial-data pin (role strap) |
| div_i | input | 1 | Shared divide / rate select pin |
| wclk_i | input | 1 | Word clock level, synchronous to `clk_i` |
| tx_bit_i | input | 1 | Serial bit from the serial port |
| low_power_o | output | 1 | High while in reset hold |
| data_oe_o | output | 1 | Output enable of the serial-data pad |
| data_o | output | 1 | Gated serial data to the pad |
| role_master_o | output | 1 | Latched role: 1 master, 0 slave |
| rate_high_o | output | 1 | High-rate mode select (master only) |
| mclk_half_o | output | 1 | Master-clock halving enable (slave only) |
| ready_o | output | 1 | Startup complete, serial output enabled |

## Verification
The bench builds the block with SETTLE_PERIODS = 5 and SYNC_STAGES = 2. With these values, the saturation of the settle counter and the behaviour after it are reached within a few dozen cycles, instead of the thousand word periods used in silicon. The two-stage synchronizer lets the bench pin down the exact edge at which hold ends and the strap is taken. Both roles are run back to back, with a mid-cycle asynchronous reset between them. A long word-clock high phase shows that the count is edge based.

// File: rtl/startup_pkg.sv
package startup_pkg;
  typedef enum logic {
    PH_HOLD   = 1'b0,
    PH_ACTIVE = 1'b1
  } phase_t;
endpackage

// File: rtl/rst_release_sync.sv
module rst_release_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_pin_n_i,
  output logic rst_sync_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_pin_n_i) begin
    if (!rst_pin_n_i) chain_q <= '0;
    else              chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/word_period_counter.sv
module word_period_counter #(
  parameter int PERIODS = 1024
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic count_en_i,
  input  logic wclk_i,
  output logic done_o
);
  localparam int CW = $clog2(PERIODS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(PERIODS);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          wclk_q;
  logic          rise;

  assign rise   = wclk_i & ~wclk_q;
  assign done_o = (cnt_q == LIMIT);

  always_comb begin
    cnt_d = cnt_q;
    if (count_en_i && rise && !done_o) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      wclk_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      wclk_q <= wclk_i;
      cnt_q  <= cnt_d;
    end
  end

  // R5
  cnt_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    cnt_q <= LIMIT);

  // R5
  done_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(done_o) |-> $past(rise));

  // R9
  level_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (wclk_i && wclk_q) |=> $stable(cnt_q));
endmodule

// File: rtl/mode_decode.sv
module mode_decode (
  input  logic active_i,
  input  logic master_i,
  input  logic div_i,
  output logic rate_high_o,
  output logic mclk_half_o
);
  always_comb begin
    rate_high_o = 1'b0;
    mclk_half_o = 1'b0;
    if (active_i) begin
      if (master_i) rate_high_o = div_i;
      else          mclk_half_o = div_i;
    end
  end
endmodule

// File: rtl/adc_startup_ctrl.sv
module adc_startup_ctrl #(
  parameter int SETTLE_PERIODS = 1024,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk_i,
  input  logic rst_pin_n_i,
  input  logic strap_i,
  input  logic div_i,
  input  logic wclk_i,
  input  logic tx_bit_i,
  output logic low_power_o,
  output logic data_oe_o,
  output logic data_o,
  output logic role_master_o,
  output logic rate_high_o,
  output logic mclk_half_o,
  output logic ready_o
);
  import startup_pkg::*;

  logic   rst_sync_n;
  phase_t phase_q, phase_d;
  logic   role_q, role_d;
  logic   active;
  logic   settled;

  rst_release_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i        (clk_i),
    .rst_pin_n_i  (rst_pin_n_i),
    .rst_sync_n_o (rst_sync_n)
  );

  always_comb begin
    phase_d = phase_q;
    role_d  = role_q;
    if (phase_q == PH_HOLD) begin
      phase_d = PH_ACTIVE;
      role_d  = strap_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      phase_q <= PH_HOLD;
      role_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      role_q  <= role_d;
    end
  end

  assign active = (phase_q == PH_ACTIVE);

  word_period_counter #(.PERIODS(SETTLE_PERIODS)) i_settle (
    .clk_i      (clk_i),
    .rst_n_i    (rst_sync_n),
    .count_en_i (active),
    .wclk_i     (wclk_i),
    .done_o     (settled)
  );

  mode_decode i_mode (
    .active_i    (active),
    .master_i    (role_q),
    .div_i       (div_i),
    .rate_high_o (rate_high_o),
    .mclk_half_o (mclk_half_o)
  );

  assign low_power_o   = ~active;
  assign data_oe_o     = active;
  assign role_master_o = role_q;
  assign ready_o       = settled;
  assign data_o        = settled & tx_bit_i;

  // R2
  leave_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    low_power_o |=> !low_power_o);

  // R3
  strap_take_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    $fell(low_power_o) |-> (role_master_o == $past(strap_i)));

  // R4
  role_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (!low_power_o && $past(!low_power_o)) |-> $stable(role_master_o));

  // R7
  mode_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !(rate_high_o && mclk_half_o));

  // R5
  ready_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    ready_o |=> ready_o);
endmodule

// File: tb/test_adc_startup_ctrl.sv
module test_adc_startup_ctrl;
  localparam int N = 5;

  logic clk = 1'b0;
  logic rst_n, strap, div, wclk, tx;
  logic lp, oe, dout, role, rh, mh, rdy;

  typedef struct {
    logic [6:0] exp;
    string      req;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  adc_startup_ctrl #(.SETTLE_PERIODS(N), .SYNC_STAGES(2)) i_adc_startup_ctrl (
    .clk_i(clk), .rst_pin_n_i(rst_n), .strap_i(strap), .div_i(div),
    .wclk_i(wclk), .tx_bit_i(tx), .low_power_o(lp), .data_oe_o(oe),
    .data_o(dout), .role_master_o(role), .rate_high_o(rh),
    .mclk_half_o(mh), .ready_o(rdy)
  );

  function automatic logic [6:0] act(logic r, logic d, logic rd, logic t);
    // {low_power, oe, role, rate_high, mclk_half, ready, data}
    return {1'b0, 1'b1, r, r & d, ~r & d, rd, rd & t};
  endfunction

  localparam logic [6:0] HOLD = 7'b100_0000;

  task automatic compare(logic [6:0] exp, string req);
    logic [6:0] got;
    got = {lp, oe, role, rh, mh, rdy, dout};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic push(logic [6:0] exp, string req);
    item_t it;
    it.exp = exp;
    it.req = req;
    q.push_back(it);
  endtask

  // monitor: pops expected items shortly after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        compare(it.exp, it.req);
      end
    end
  end

  task automatic pulse(int hi, int lo);
    wclk = 1'b1;
    repeat (hi) @(negedge clk);
    wclk = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic release_and_check(logic r);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    push(HOLD, "R2 still in hold after two edges");
    @(negedge clk);
    push(act(r, div, 1'b0, tx), "R2 R3 R6 leave hold and take strap");
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #100000;
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; strap = 1'b1; div = 1'b1; wclk = 1'b0; tx = 1'b1;
    repeat (3) @(negedge clk);
    push(HOLD, "R1 reset state");

    // master role
    release_and_check(1'b1);
    @(negedge clk);
    strap = 1'b0;
    push(act(1'b1, div, 1'b0, tx), "R4 strap change ignored; R7 high-rate");

    // R9: first pulse has a long high phase, counts once
    pulse(7, 3);
    push(act(1'b1, div, 1'b0, tx), "R9 long high counts once; R6 zeros");
    for (int k = 2; k <= N + 2; k++) begin
      pulse(2, 2);
      push(act(1'b1, div, k >= N, tx), "R5 ready after settle periods");
    end
    @(negedge clk);
    tx = 1'b0;
    push(act(1'b1, div, 1'b1, tx), "R6 data follows tx bit");
    @(negedge clk);
    div = 1'b0;
    push(act(1'b1, div, 1'b1, tx), "R7 base-rate in master");
    @(negedge clk);

    // R1 async assertion mid-cycle
    @(posedge clk);
    #2;
    rst_n = 1'b0;
    #1;
    compare(HOLD, "R1 asynchronous reset entry");
    @(negedge clk);

    // slave role
    strap = 1'b0; div = 1'b1; tx = 1'b1;
    @(negedge clk);
    release_and_check(1'b0);
    @(negedge clk);
    strap = 1'b1;
    push(act(1'b0, div, 1'b0, tx), "R4 R8 slave halves mclk, strap ignored");
    for (int k = 1; k <= N; k++) begin
      pulse(1, 3);
      push(act(1'b0, div, k >= N, tx), "R5 slave settle count");
    end
    @(negedge clk);
    div = 1'b0;
    push(act(1'b0, div, 1'b1, tx), "R8 slave passes mclk");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule